// File: doc/BRIEF.md
# Posted-Write Ordering and Read-Ahead Controller

This block sits in the control path of a two-port bus bridge. Each port is called a side: side 0 is the primary (upstream) side and side 1 is the secondary (downstream) side. A memory write from either side is posted. It is acknowledged to its originator in the same cycle and held in a queue for that direction, and the queue hands it to the opposite side later. Queue 0 holds writes that came from the primary side and delivers them to the secondary side. Queue 1 works the other way. The two queues never wait on each other, so one direction can never stall the other.

Reads are ordered behind the writes. A read from a side is retried while that side's queue still holds posted writes. A retried read also raises a flush flag for that side. While the flag is set, new writes from that side are refused, so the queue is able to empty. The requester repeats the read, and an attempt made once the queue is empty is accepted.

For every accepted read the block also reports whether the data path may read ahead. The decision uses the read command, the side the read came from, a prefetchable-window hit flag, and a configuration bit that disables read-ahead for secondary-side reads. Bus signalling, address decoding and data buffering are outside this block.

Top module: `post_order_ctrl`

## Requirements
- R1: A write request on side s is acknowledged (`wr_ack_o[s]`=1) in the same cycle when queue s has room and no flush is pending for side s. The write becomes visible at the far side (`fwd_valid_o[s]`) no earlier than the next cycle.
- R2: Queue s presents its oldest entry on `fwd_valid_o[s]`/`fwd_addr_o[s]`/`fwd_data_o[s]` while it is non-empty. The entry is removed on a cycle where `fwd_ready_i[s]` is 1. Queue 0 is drained toward the secondary side and queue 1 toward the primary side.
- R3: A write request to a queue holding DEPTH entries gets `wr_retry_o[s]`=1 and `wr_ack_o[s]`=0, and it is not stored.
- R4: Writes within one queue leave in exactly the order they were accepted.
- R5: Whether a write or read from side s is accepted depends only on side s's queue and flush state. A full or busy queue on the other side has no effect.
- R6: A read on side s is retried (`rd_retry_o[s]`=1, `rd_ack_o[s]`=0) while queue s is non-empty. It is accepted (`rd_ack_o[s]`=1) in a cycle where queue s is empty.
- R7: A retried read sets a flush flag for side s, starting the next cycle. The flag stays set up to and including the first cycle in which queue s is empty. While it is set, writes from side s are retried even if the queue has room.
- R8: The read command field is 2 bits wide: 00 plain memory read, 01 memory read line, 10 memory read multiple, 11 I/O read. Commands 01 and 10 are always allowed to read ahead (`rd_prefetch_o[s]`=1 on acceptance), from either side.
- R9: A plain memory read (00) accepted from side 0 may read ahead only when `rd_pf_hit_i[0]` is 1.
- R10: A plain memory read (00) accepted from side 1 may read ahead only when `cfg_sec_pf_dis_i` is 0. `rd_pf_hit_i[1]` is ignored.
- R11: An I/O read (11) never reads ahead. `rd_prefetch_o[s]` is 0 in every cycle without `rd_ack_o[s]`.
- R12: After reset both queues are empty, no flush flag is set, and with no requests every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sec_pf_dis_i | input | 1 | Disables read-ahead for plain reads from side 1 |
| wr_req_i | input | 2 | Write request per side |
| wr_addr_i | input | 2x ADDR_W | Write address per side |
| wr_data_i | input | 2x DATA_W | Write data per side |
| wr_ack_o | output | 2 | Write posted (complete on originating side) |
| wr_retry_o | output | 2 | Write refused, retry later |
| fwd_valid_o | output | 2 | Queue s has a write for the opposite side |
| fwd_ready_i | input | 2 | Opposite side takes the head of queue s |
| fwd_addr_o | output | 2x ADDR_W | Head address of queue s |
| fwd_data_o | output | 2x DATA_W | Head data of queue s |
| rd_req_i | input | 2 | Read request per side |
| rd_cmd_i | input | 2x2 | Read command per side |
| rd_pf_hit_i | input | 2 | Address hits the prefetchable window |
| rd_ack_o | output | 2 | Read accepted |
| rd_retry_o | output | 2 | Read retried, flush in progress |
| rd_prefetch_o | output | 2 | Accepted read may read ahead |

## Verification
Some rules are checked on every cycle:
- an accepted read always finds its own queue empty;
- no write is accepted into a full queue or while a flush is pending;
- a waiting queue head stays stable;
- I/O reads, line and multiple reads, and disabled secondary reads always receive the read-ahead answer the table requires.

Other properties depend on a whole sequence, so only the bench scenarios can show them:
- the order in which written data leaves a queue;
- that a refused write never appears at the far side;
- that one full queue leaves the other direction free;
- that the flush flag sets and clears, which takes a retried read followed by a drain.

// File: rtl/post_order_pkg.sv
package post_order_pkg;
  typedef enum logic [1:0] {
    CMD_MEM_RD   = 2'b00,
    CMD_RD_LINE  = 2'b01,
    CMD_RD_MULTI = 2'b10,
    CMD_IO_RD    = 2'b11
  } rd_cmd_e;

  localparam int unsigned SIDE_PRI = 0;
  localparam int unsigned SIDE_SEC = 1;
  localparam int unsigned N_SIDES  = 2;
endpackage

// File: rtl/post_fifo.sv
module post_fifo #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end
endmodule

// File: rtl/flush_gate.sv
module flush_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic full_i,
  input  logic wr_req_i,
  input  logic rd_req_i,
  output logic wr_ack_o,
  output logic wr_retry_o,
  output logic rd_ack_o,
  output logic rd_retry_o,
  output logic flush_pend_o
);
  logic flush_pend_q;

  assign flush_pend_o = flush_pend_q;
  assign wr_ack_o     = wr_req_i && !full_i && !flush_pend_q;
  assign wr_retry_o   = wr_req_i && !wr_ack_o;
  assign rd_ack_o     = rd_req_i && empty_i;
  assign rd_retry_o   = rd_req_i && !empty_i;

  // held until the queue is seen empty, so new writes cannot starve the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_pend_q <= 1'b0;
    else         flush_pend_q <= !empty_i && (flush_pend_q || rd_req_i);
  end
endmodule

// File: rtl/pf_policy.sv
module pf_policy
  import post_order_pkg::*;
#(
  parameter int unsigned SIDE = SIDE_PRI
) (
  input  logic       rd_ack_i,
  input  logic [1:0] rd_cmd_i,
  input  logic       pf_hit_i,
  input  logic       sec_pf_dis_i,
  output logic       prefetch_o
);
  logic plain_ok;

  generate
    if (SIDE == SIDE_PRI) begin : g_pri
      assign plain_ok = pf_hit_i;
    end else begin : g_sec
      assign plain_ok = !sec_pf_dis_i;
    end
  endgenerate

  always_comb begin
    prefetch_o = 1'b0;
    if (rd_ack_i) begin
      unique case (rd_cmd_e'(rd_cmd_i))
        CMD_RD_LINE, CMD_RD_MULTI: prefetch_o = 1'b1;
        CMD_MEM_RD:                prefetch_o = plain_ok;
        default:                   prefetch_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/post_order_ctrl.sv
module post_order_ctrl
  import post_order_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_sec_pf_dis_i,
  input  logic [N_SIDES-1:0]            wr_req_i,
  input  logic [N_SIDES-1:0][ADDR_W-1:0] wr_addr_i,
  input  logic [N_SIDES-1:0][DATA_W-1:0] wr_data_i,
  output logic [N_SIDES-1:0]            wr_ack_o,
  output logic [N_SIDES-1:0]            wr_retry_o,
  output logic [N_SIDES-1:0]            fwd_valid_o,
  input  logic [N_SIDES-1:0]            fwd_ready_i,
  output logic [N_SIDES-1:0][ADDR_W-1:0] fwd_addr_o,
  output logic [N_SIDES-1:0][DATA_W-1:0] fwd_data_o,
  input  logic [N_SIDES-1:0]            rd_req_i,
  input  logic [N_SIDES-1:0][1:0]       rd_cmd_i,
  input  logic [N_SIDES-1:0]            rd_pf_hit_i,
  output logic [N_SIDES-1:0]            rd_ack_o,
  output logic [N_SIDES-1:0]            rd_retry_o,
  output logic [N_SIDES-1:0]            rd_prefetch_o
);
  localparam int unsigned ENT_W = ADDR_W + DATA_W;

  logic [N_SIDES-1:0] q_empty, q_full, flush_pend;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic [ENT_W-1:0] head;

    flush_gate u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .empty_i     (q_empty[s]),
      .full_i      (q_full[s]),
      .wr_req_i    (wr_req_i[s]),
      .rd_req_i    (rd_req_i[s]),
      .wr_ack_o    (wr_ack_o[s]),
      .wr_retry_o  (wr_retry_o[s]),
      .rd_ack_o    (rd_ack_o[s]),
      .rd_retry_o  (rd_retry_o[s]),
      .flush_pend_o(flush_pend[s])
    );

    post_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_queue (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (wr_ack_o[s]),
      .push_data_i({wr_addr_i[s], wr_data_i[s]}),
      .pop_i      (fwd_ready_i[s]),
      .head_o     (head),
      .empty_o    (q_empty[s]),
      .full_o     (q_full[s])
    );

    assign fwd_valid_o[s] = !q_empty[s];
    assign fwd_addr_o[s]  = q_empty[s] ? '0 : head[ENT_W-1:DATA_W];
    assign fwd_data_o[s]  = q_empty[s] ? '0 : head[DATA_W-1:0];

    pf_policy #(.SIDE(s)) u_pf (
      .rd_ack_i    (rd_ack_o[s]),
      .rd_cmd_i    (rd_cmd_i[s]),
      .pf_hit_i    (rd_pf_hit_i[s]),
      .sec_pf_dis_i(cfg_sec_pf_dis_i),
      .prefetch_o  (rd_prefetch_o[s])
    );
  end
endmodule

// File: rtl/post_order_chk.sv
module post_order_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_sec_pf_dis_i,
  input logic [1:0]             wr_req_i,
  input logic [1:0]             wr_ack_o,
  input logic [1:0]             wr_retry_o,
  input logic [1:0]             q_full,
  input logic [1:0]             flush_pend,
  input logic [1:0]             fwd_valid_o,
  input logic [1:0]             fwd_ready_i,
  input logic [1:0][ADDR_W-1:0] fwd_addr_o,
  input logic [1:0][DATA_W-1:0] fwd_data_o,
  input logic [1:0]             rd_ack_o,
  input logic [1:0]             rd_retry_o,
  input logic [1:0][1:0]        rd_cmd_i,
  input logic [1:0]             rd_prefetch_o
);
  for (genvar s = 0; s < 2; s++) begin : g_chk
    p_ack_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_ack_o[s] && wr_retry_o[s]));
    p_head_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_valid_o[s] && !fwd_ready_i[s] |=>
        fwd_valid_o[s] && $stable(fwd_addr_o[s]) && $stable(fwd_data_o[s]));
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ack_o[s] |-> !q_full[s]);
    p_rd_after_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_ack_o[s] |-> !fwd_valid_o[s] && !rd_retry_o[s]);
    p_flush_blocks_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_pend[s] |-> !wr_ack_o[s]);
    p_retry_sets_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_retry_o[s] |=> flush_pend[s]);
    p_line_multi_pf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_ack_o[s] && (rd_cmd_i[s] == 2'b01 || rd_cmd_i[s] == 2'b10) |-> rd_prefetch_o[s]);
    p_io_no_pf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_cmd_i[s] == 2'b11 || !rd_ack_o[s]) |-> !rd_prefetch_o[s]);
  end

  p_sec_pf_dis_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o[1] && rd_cmd_i[1] == 2'b00 && cfg_sec_pf_dis_i |-> !rd_prefetch_o[1]);
endmodule

bind post_order_ctrl post_order_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_sec_pf_dis_i(cfg_sec_pf_dis_i),
  .wr_req_i        (wr_req_i),
  .wr_ack_o        (wr_ack_o),
  .wr_retry_o      (wr_retry_o),
  .q_full          (q_full),
  .flush_pend      (flush_pend),
  .fwd_valid_o     (fwd_valid_o),
  .fwd_ready_i     (fwd_ready_i),
  .fwd_addr_o      (fwd_addr_o),
  .fwd_data_o      (fwd_data_o),
  .rd_ack_o        (rd_ack_o),
  .rd_retry_o      (rd_retry_o),
  .rd_cmd_i        (rd_cmd_i),
  .rd_prefetch_o   (rd_prefetch_o)
);

// File: tb/post_order_ctrl_test.sv
module post_order_ctrl_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_sec_pf_dis_i = 1'b0;
  logic [1:0] wr_req_i = '0;
  logic [1:0][ADDR_W-1:0] wr_addr_i = '0;
  logic [1:0][DATA_W-1:0] wr_data_i = '0;
  logic [1:0] wr_ack_o, wr_retry_o, fwd_valid_o;
  logic [1:0] fwd_ready_i = '0;
  logic [1:0][ADDR_W-1:0] fwd_addr_o;
  logic [1:0][DATA_W-1:0] fwd_data_o;
  logic [1:0] rd_req_i = '0;
  logic [1:0][1:0] rd_cmd_i = '0;
  logic [1:0] rd_pf_hit_i = '0;
  logic [1:0] rd_ack_o, rd_retry_o, rd_prefetch_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  post_order_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_sec_pf_dis_i(cfg_sec_pf_dis_i),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_ack_o(wr_ack_o), .wr_retry_o(wr_retry_o),
    .fwd_valid_o(fwd_valid_o), .fwd_ready_i(fwd_ready_i),
    .fwd_addr_o(fwd_addr_o), .fwd_data_o(fwd_data_o),
    .rd_req_i(rd_req_i), .rd_cmd_i(rd_cmd_i), .rd_pf_hit_i(rd_pf_hit_i),
    .rd_ack_o(rd_ack_o), .rd_retry_o(rd_retry_o), .rd_prefetch_o(rd_prefetch_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    step();
    wr_req_i = '0; rd_req_i = '0; fwd_ready_i = '0;
  endtask

  // one write cycle on side s, check ack/retry at negedge
  task automatic push(input int s, input logic [31:0] a, input logic [31:0] d, input bit exp_ack, input string tag);
    step();
    rd_req_i = '0; fwd_ready_i = '0;
    wr_req_i = '0; wr_req_i[s] = 1'b1; wr_addr_i[s] = a; wr_data_i[s] = d;
    @(negedge clk);
    chk(wr_ack_o[s] == exp_ack && wr_retry_o[s] == !exp_ack, tag, {wr_ack_o[s], wr_retry_o[s]}, {exp_ack, !exp_ack});
  endtask

  task automatic pop(input int q, input logic [31:0] a, input logic [31:0] d, input string tag);
    step();
    wr_req_i = '0; rd_req_i = '0; fwd_ready_i = '0; fwd_ready_i[q] = 1'b1;
    @(negedge clk);
    chk(fwd_valid_o[q] && fwd_addr_o[q] == a && fwd_data_o[q] == d, tag,
        {fwd_addr_o[q], fwd_data_o[q]}, {a, d});
  endtask

  function automatic bit exp_pf(input int s, input int cmd, input bit hit, input bit dis);
    if (cmd == 1 || cmd == 2) return 1'b1;
    if (cmd == 3) return 1'b0;
    return (s == 0) ? hit : !dis;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk({wr_ack_o, wr_retry_o, fwd_valid_o, rd_ack_o, rd_retry_o, rd_prefetch_o} == '0,
        "R12 reset outputs", {wr_ack_o, wr_retry_o, fwd_valid_o, rd_ack_o, rd_retry_o, rd_prefetch_o}, 0);
  endtask

  task automatic t_post_order();
    push(0, 32'h1000, 32'hA1, 1, "R1 post ack");
    chk(!fwd_valid_o[0], "R1 not forwarded same cycle", fwd_valid_o[0], 0);
    push(0, 32'h1004, 32'hA2, 1, "R1 post ack");
    push(0, 32'h1008, 32'hA3, 1, "R1 post ack");
    idle();
    @(negedge clk);
    chk(fwd_valid_o[0] && !fwd_valid_o[1], "R2 direction", fwd_valid_o, 2'b01);
    pop(0, 32'h1000, 32'hA1, "R4 order 1");
    pop(0, 32'h1004, 32'hA2, "R4 order 2");
    pop(0, 32'h1008, 32'hA3, "R4 order 3");
    idle();
    @(negedge clk);
    chk(!fwd_valid_o[0], "R2 queue drained", fwd_valid_o[0], 0);
  endtask

  task automatic t_full_indep();
    for (int i = 0; i < DEPTH; i++) push(1, 32'h2000 + i, 32'hB0 + i, 1, "R1 fill");
    push(1, 32'h2FFF, 32'hBAD, 0, "R3 full retry");
    push(0, 32'h3000, 32'hC0, 1, "R5 other side accepts");
    step();
    wr_req_i = '0; fwd_ready_i = '0; rd_req_i = '0; rd_req_i[0] = 1'b1; rd_cmd_i[0] = 2'b11;
    @(negedge clk);
    chk(rd_retry_o[0] && !rd_ack_o[1], "R6 own queue busy", rd_retry_o[0], 1);
    idle();
    for (int i = 0; i < DEPTH; i++) pop(1, 32'h2000 + i, 32'hB0 + i, "R4 full drain order");
    idle();
    @(negedge clk);
    chk(!fwd_valid_o[1], "R3 refused write not stored", fwd_valid_o[1], 0);
    pop(0, 32'h3000, 32'hC0, "R5 other queue intact");
    idle();
  endtask

  task automatic t_flush();
    push(0, 32'h4000, 32'hD0, 1, "R1 pre flush");
    push(0, 32'h4004, 32'hD1, 1, "R1 pre flush");
    step();
    wr_req_i = '0; rd_req_i = 2'b11; rd_cmd_i = '0;
    @(negedge clk);
    chk(rd_retry_o[0] && !rd_ack_o[0], "R6 read retried", {rd_ack_o[0], rd_retry_o[0]}, 2'b01);
    chk(rd_ack_o[1], "R5 other side read accepted", rd_ack_o[1], 1);
    push(0, 32'h4FFF, 32'hEE, 0, "R7 write blocked by flush");
    pop(0, 32'h4000, 32'hD0, "R4 flush order");
    pop(0, 32'h4004, 32'hD1, "R4 flush order");
    step();
    fwd_ready_i = '0; rd_req_i = 2'b01; rd_cmd_i[0] = 2'b00;
    wr_req_i = 2'b01; wr_addr_i[0] = 32'h4100; wr_data_i[0] = 32'hF0;
    @(negedge clk);
    chk(rd_ack_o[0], "R6 read accepted after drain", rd_ack_o[0], 1);
    chk(wr_retry_o[0], "R7 flush held in empty cycle", wr_retry_o[0], 1);
    push(0, 32'h4100, 32'hF0, 1, "R7 flush cleared");
    idle();
    pop(0, 32'h4100, 32'hF0, "R2 post flush write");
    idle();
  endtask

  task automatic t_prefetch();
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++)
        for (int h = 0; h < 2; h++)
          for (int d = 0; d < 2; d++) begin
            step();
            wr_req_i = '0; fwd_ready_i = '0; rd_req_i = '0; rd_req_i[s] = 1'b1;
            rd_cmd_i[s] = 2'(c); rd_pf_hit_i = '0; rd_pf_hit_i[s] = 1'(h);
            cfg_sec_pf_dis_i = 1'(d);
            @(negedge clk);
            chk(rd_ack_o[s] && rd_prefetch_o[s] == exp_pf(s, c, 1'(h), 1'(d)),
                (c == 3) ? "R11 io" : (c != 0) ? "R8 line/multi" : (s == 0) ? "R9 pri plain" : "R10 sec plain",
                {rd_ack_o[s], rd_prefetch_o[s]}, {1'b1, exp_pf(s, c, 1'(h), 1'(d))});
          end
    idle();
    rd_cmd_i = '0; rd_pf_hit_i = 2'b11;
    @(negedge clk);
    chk(rd_prefetch_o == '0, "R11 no prefetch without ack", rd_prefetch_o, 0);
  endtask

  initial begin
    t_reset();
    t_post_order();
    t_full_indep();
    t_flush();
    t_prefetch();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule